// File: doc/BRIEF.md
# Per-Core Banked Timer Address Router

This block puts one address space in front of an array of timer and watchdog register blocks, one pair for each core. Each access carries the index of the core that issues it. Two windows at the bottom of the map are banked on that index, so any core can use the same addresses to reach its own timer and its own watchdog. Every individual block also has a fixed direct window, so software on one core can reach another core's timer or watchdog.

Every window is 32 bytes wide. The window number is the address divided by 0x20. Inside a window, bits [4:2] select a 32-bit register. Requests use a valid/ready handshake. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. The response appears on the next cycle and is held, with stable data and error flag, until `rsp_ready` is high. While a response waits, `req_ready` stays low, so back-pressure on the response stalls new requests. An access that cannot be mapped does not change any block. Its response has error set and data zero, and it sets a sticky error output that only reset clears.

Each block here is a small down-counter stub, so the routing can be observed. The array always holds `MAX_CORES` pairs and reset clears all of them. Only the first `NUM_CORES` pairs can be addressed and drive interrupts.

Top module: `core_timer_router`

## Requirements
- R1: Window 0 (addresses 0x00-0x1F) reaches the timer of the core given by `req_core`. Window 1 (0x20-0x3F) reaches that core's watchdog.
- R2: Window 2+2k reaches the timer of core k and window 3+2k reaches the watchdog of core k, for k below `NUM_CORES`. Each accepted write changes at most one block.
- R3: `irq[2k]` is the interrupt of core k's timer and `irq[2k+1]` is the interrupt of core k's watchdog.
- R4: An access through window 0 or 1 with `req_core` >= `NUM_CORES` is an error. A write is dropped, and a read returns zero with `rsp_err` set.
- R5: The following accesses are errors with the same effect as in R4:
  - `req_size` other than 2, meaning 4 bytes;
  - `req_addr[1:0]` nonzero;
  - register offset 0x10 or above inside a window;
  - a window number at or above 2+2*`NUM_CORES`.
- R6: `err_sticky` rises on the cycle after the first error response is produced and stays high until reset.
- R7: The response follows acceptance by one cycle. While `rsp_valid` is high and `rsp_ready` is low:
  - `rsp_rdata` and `rsp_err` hold their values;
  - `req_ready` is low.
- R8: After reset:
  - `rsp_valid`, `err_sticky` and `irq` are zero;
  - every register of every block reads zero.
- R9: Block registers:
  - offset 0x0 is the reload value, and writing it also sets the count;
  - offset 0x4 is the count;
  - offset 0x8 is control, with bit 0 enable and bit 1 auto-reload;
  - offset 0xC is the interrupt status in bit 0, cleared by writing 1.
- R10: An enabled block with a nonzero count decrements it by one every cycle. The step from 1 to 0 sets the status bit. With auto-reload the count is instead reloaded from the reload value; without auto-reload it stays at zero.
- R11: Setting enable while the count is zero and auto-reload is set in the same write loads the count from the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | log2 of access bytes, only 2 is legal |
| req_core | input | CORE_W | Index of the requesting core |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | DATA_W | Read data, zero for writes and errors |
| rsp_err | output | 1 | Access was unmapped or illegal |
| err_sticky | output | 1 | Set by any error response, cleared by reset |
| irq | output | 2*NUM_CORES | Interrupts: timer then watchdog for each core |

## Verification
The bench builds the router with `MAX_CORES`=4 and `NUM_CORES`=3. This leaves one core index and one pair of direct windows (windows 8 and 9) that exist in the address space but are beyond the configured count. Those are the alias and direct out-of-range errors, while three real cores let alias and direct views be cross-checked between different cores. A 12-bit address also reaches windows beyond the whole array.

// File: rtl/tmr_router_pkg.sv
package tmr_router_pkg;

  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STATUS = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_AUTO_BIT = 1;
  localparam logic [1:0] WORD_SIZE = 2'd2;
  localparam int WIN_SHIFT = 5;
  localparam int ALIAS_WINDOWS = 2;

endpackage

// File: rtl/tmr_win_decode.sv
module tmr_win_decode
  import tmr_router_pkg::*;
#(
  parameter int MAX_CORES = 4,
  parameter int NUM_CORES = 2,
  parameter int ADDR_W    = 12,
  parameter int CORE_W    = 2,
  parameter int IDX_W     = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [CORE_W-1:0] core,
  output logic              ok,
  output logic [IDX_W-1:0]  blk_idx,
  output reg_sel_e          reg_sel
);
  localparam int WIN_W = ADDR_W - WIN_SHIFT;
  localparam int LAST_WIN = ALIAS_WINDOWS + 2 * NUM_CORES;

  logic [WIN_W-1:0]  win;
  logic [4:0]        offs;
  logic [WIN_W-1:0]  blk_full;
  logic              core_ok;
  logic              shape_ok;

  assign win  = addr[ADDR_W-1:WIN_SHIFT];
  assign offs = addr[WIN_SHIFT-1:0];
  assign core_ok  = {1'b0, core} < (CORE_W+1)'(NUM_CORES);
  assign shape_ok = (size == WORD_SIZE) && (offs[1:0] == 2'b00) && !offs[4];
  assign reg_sel  = reg_sel_e'(offs[3:2]);

  always_comb begin
    ok       = 1'b0;
    blk_full = '0;
    if (win == WIN_W'(0)) begin
      blk_full = WIN_W'(core) << 1;
      ok       = core_ok;
    end else if (win == WIN_W'(1)) begin
      blk_full = (WIN_W'(core) << 1) | WIN_W'(1);
      ok       = core_ok;
    end else if (win < WIN_W'(LAST_WIN)) begin
      blk_full = win - WIN_W'(ALIAS_WINDOWS);
      ok       = 1'b1;
    end
    ok = ok && shape_ok;
  end

  assign blk_idx = IDX_W'(blk_full);

  initial begin
    AST_CORE_RANGE: assert (NUM_CORES >= 1 && NUM_CORES <= MAX_CORES); // R4
  end
endmodule

// File: rtl/tmr_block_stub.sv
module tmr_block_stub
  import tmr_router_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] count_q;
  logic [1:0]        ctrl_q;
  logic              status_q;
  logic              ticking;

  assign ticking = ctrl_q[CTRL_EN_BIT] && (count_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      count_q  <= '0;
      ctrl_q   <= '0;
      status_q <= 1'b0;
    end else begin
      if (ticking) begin
        if (count_q == DATA_W'(1)) begin
          status_q <= 1'b1;
          count_q  <= ctrl_q[CTRL_AUTO_BIT] ? reload_q : '0;
        end else begin
          count_q <= count_q - DATA_W'(1);
        end
      end
      if (wr_en) begin
        case (reg_sel)
          REG_RELOAD: begin
            reload_q <= wr_data;
            count_q  <= wr_data;
          end
          REG_COUNT: count_q <= wr_data;
          REG_CTRL: begin
            ctrl_q <= wr_data[1:0];
            if (!ctrl_q[CTRL_EN_BIT] && wr_data[CTRL_EN_BIT] &&
                wr_data[CTRL_AUTO_BIT] && (count_q == '0))
              count_q <= reload_q;
          end
          default: if (wr_data[0]) status_q <= 1'b0;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_sel)
      REG_RELOAD: rd_data = reload_q;
      REG_COUNT:  rd_data = count_q;
      REG_CTRL:   rd_data = {{(DATA_W-2){1'b0}}, ctrl_q};
      default:    rd_data = {{(DATA_W-1){1'b0}}, status_q};
    endcase
  end

  assign irq = status_q;

  AST_EXPIRE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CTRL_EN_BIT] && count_q == DATA_W'(1) && !wr_en) |=> irq); // R10
  AST_HALT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CTRL_AUTO_BIT] && count_q == '0 && !wr_en) |=> count_q == '0); // R10
endmodule

// File: rtl/core_timer_router.sv
module core_timer_router
  import tmr_router_pkg::*;
#(
  parameter int MAX_CORES = 4,
  parameter int NUM_CORES = 2,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int CORE_W    = (MAX_CORES > 1) ? $clog2(MAX_CORES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [1:0]             req_size,
  input  logic [CORE_W-1:0]      req_core,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic                   rsp_err,
  output logic                   err_sticky,
  output logic [2*NUM_CORES-1:0] irq
);
  localparam int NBLK  = 2 * MAX_CORES;
  localparam int IDX_W = $clog2(NBLK);

  logic              acc_fire;
  logic              dec_ok;
  logic [IDX_W-1:0]  dec_blk;
  reg_sel_e          dec_reg;
  logic [NBLK-1:0]   blk_wr;
  logic [NBLK-1:0]   blk_irq;
  logic [DATA_W-1:0] blk_rdata [NBLK];
  logic [DATA_W-1:0] sel_rdata;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc_fire  = req_valid && req_ready;

  tmr_win_decode #(
    .MAX_CORES(MAX_CORES), .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W),
    .CORE_W(CORE_W), .IDX_W(IDX_W)
  ) u_decode (
    .addr(req_addr), .size(req_size), .core(req_core),
    .ok(dec_ok), .blk_idx(dec_blk), .reg_sel(dec_reg)
  );

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    assign blk_wr[i] = acc_fire && req_write && dec_ok && (dec_blk == IDX_W'(i));
    tmr_block_stub #(.DATA_W(DATA_W)) u_blk (
      .clk(clk), .rst_n(rst_n), .wr_en(blk_wr[i]), .reg_sel(dec_reg),
      .wr_data(req_wdata), .rd_data(blk_rdata[i]), .irq(blk_irq[i])
    );
  end

  assign sel_rdata = blk_rdata[dec_blk];
  assign irq = blk_irq[2*NUM_CORES-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_err    <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      if (acc_fire) begin
        rsp_valid <= 1'b1;
        rsp_err   <= !dec_ok;
        rsp_rdata <= (dec_ok && !req_write) ? sel_rdata : '0;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (rsp_valid && rsp_err) err_sticky <= 1'b1;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(blk_wr)); // R2
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))); // R7
  AST_ERR_NODATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rsp_rdata == '0); // R4
  AST_ERR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky); // R6
endmodule

// File: tb/core_timer_router_bench.sv
module core_timer_router_bench;
  localparam int MAXC = 4;
  localparam int NC   = 3;
  localparam int AW   = 12;
  localparam int DW   = 32;
  localparam int CW   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = 2'd2;
  logic [CW-1:0] req_core = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, err_sticky;
  logic [DW-1:0] rsp_rdata;
  logic [2*NC-1:0] irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  core_timer_router #(.MAX_CORES(MAXC), .NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW))
  u_core_timer_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_core(req_core), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .err_sticky(err_sticky), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int core, input logic [1:0] sz,
                        output logic [DW-1:0] rd, output logic er);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    req_core = CW'(core); req_size = sz;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; er = rsp_err;
    check(rsp_valid === 1'b1, "R7 rsp_valid one cycle after accept", DW'(rsp_valid), 1);
  endtask

  task automatic wr32(input logic [AW-1:0] a, input logic [DW-1:0] d, input int core);
    logic [DW-1:0] rd; logic er;
    access(1'b1, a, d, core, 2'd2, rd, er);
  endtask

  task automatic rd32(input logic [AW-1:0] a, input int core, output logic [DW-1:0] rd);
    logic er;
    access(1'b0, a, '0, core, 2'd2, rd, er);
  endtask

  function automatic logic [AW-1:0] tmr_win(input int k);
    return AW'((2 + 2*k) * 32);
  endfunction
  function automatic logic [AW-1:0] wdg_win(input int k);
    return AW'((3 + 2*k) * 32);
  endfunction

  task automatic t_reset;
    logic [DW-1:0] v;
    check(rsp_valid === 1'b0 && err_sticky === 1'b0, "R8 rsp_valid/err_sticky at reset",
          DW'({rsp_valid, err_sticky}), 0);
    check(irq === '0, "R8 irq at reset", DW'(irq), 0);
    for (int b = 0; b < 2*NC; b++) begin
      for (int r = 0; r < 4; r++) begin
        rd32(AW'((2 + b) * 32 + r*4), 0, v);
        check(v === '0, "R8 register zero after reset", v, 0);
      end
    end
    check(err_sticky === 1'b0, "R8 no error from legal reads", DW'(err_sticky), 0);
  endtask

  task automatic t_alias;
    logic [DW-1:0] v;
    wr32(12'h000, 32'hA1, 1);
    wr32(12'h020, 32'hB1, 1);
    rd32(tmr_win(1), 0, v);
    check(v === 32'hA1, "R1 alias timer write lands in core1 timer", v, 32'hA1);
    rd32(wdg_win(1), 0, v);
    check(v === 32'hB1, "R1 alias watchdog write lands in core1 watchdog", v, 32'hB1);
    rd32(tmr_win(0), 0, v);
    check(v === 32'h0, "R1 core0 timer untouched", v, 0);
    wr32(tmr_win(2), 32'hC2, 0);
    rd32(12'h000, 2, v);
    check(v === 32'hC2, "R1 core2 alias reads its own timer", v, 32'hC2);
    rd32(12'h020, 2, v);
    check(v === 32'h0, "R1 core2 alias watchdog distinct", v, 0);
  endtask

  task automatic t_direct;
    logic [DW-1:0] v;
    wr32(tmr_win(0), 32'h1234, 2);
    rd32(12'h000, 0, v);
    check(v === 32'h1234, "R2 direct timer core0 seen through alias", v, 32'h1234);
    wr32(wdg_win(2), 32'h77, 0);
    rd32(12'h020, 2, v);
    check(v === 32'h77, "R2 direct watchdog core2 seen through alias", v, 32'h77);
    rd32(wdg_win(2) + 12'h4, 1, v);
    check(v === 32'h77, "R9 reload write also sets count", v, 32'h77);
  endtask

  task automatic t_errors;
    logic [DW-1:0] v; logic er;
    check(err_sticky === 1'b0, "R6 sticky low before any error", DW'(err_sticky), 0);
    access(1'b1, 12'h000, 32'h55, 3, 2'd2, v, er);
    check(er === 1'b1, "R4 alias write from core3 flagged", DW'(er), 1);
    access(1'b0, 12'h020, '0, 3, 2'd2, v, er);
    check(er === 1'b1 && v === '0, "R4 alias read from core3 error and zero", v, 0);
    access(1'b1, tmr_win(0), 32'h55, 0, 2'd1, v, er);
    check(er === 1'b1, "R5 halfword access flagged", DW'(er), 1);
    access(1'b1, tmr_win(0) + 12'h2, 32'h55, 0, 2'd2, v, er);
    check(er === 1'b1, "R5 misaligned access flagged", DW'(er), 1);
    access(1'b0, tmr_win(0) + 12'h10, '0, 0, 2'd2, v, er);
    check(er === 1'b1 && v === '0, "R5 offset 0x10 flagged", v, 0);
    access(1'b1, tmr_win(3), 32'h55, 0, 2'd2, v, er);
    check(er === 1'b1, "R5 direct window of unconfigured core flagged", DW'(er), 1);
    access(1'b1, 12'hFE0, 32'h55, 0, 2'd2, v, er);
    check(er === 1'b1, "R5 window past array flagged", DW'(er), 1);
    rd32(tmr_win(0), 1, v);
    check(v === 32'h1234, "R5 dropped writes left core0 timer intact", v, 32'h1234);
    rd32(12'h000, 2, v);
    check(v === 32'hC2, "R4 dropped alias write left blocks intact", v, 32'hC2);
    check(err_sticky === 1'b1, "R6 sticky set after errors", DW'(err_sticky), 1);
    repeat (3) @(negedge clk);
    check(err_sticky === 1'b1, "R6 sticky holds after legal traffic", DW'(err_sticky), 1);
  endtask

  task automatic t_backpressure;
    logic [DW-1:0] first;
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = tmr_win(0); req_core = '0; req_size = 2'd2;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    first = rsp_rdata;
    check(first === 32'h1234, "R7 stalled read data", first, 32'h1234);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(rsp_valid === 1'b1 && rsp_rdata === first, "R7 response held under stall",
            rsp_rdata, first);
      check(req_ready === 1'b0, "R7 req_ready low under stall", DW'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_valid === 1'b0 && req_ready === 1'b1, "R7 response drains",
          DW'({rsp_valid, req_ready}), 1);
  endtask

  task automatic t_count;
    logic [DW-1:0] a, b;
    wr32(tmr_win(1), 32'd20, 0);
    wr32(tmr_win(1) + 12'h8, 32'h1, 0);
    rd32(tmr_win(1) + 12'h4, 0, a);
    rd32(tmr_win(1) + 12'h4, 0, b);
    check(b === a - 1, "R10 count steps by one per cycle", b, a - 1);
    repeat (25) @(negedge clk);
    rd32(tmr_win(1) + 12'h4, 0, a);
    check(a === '0, "R10 one-shot stops at zero", a, 0);
    check(irq === 6'b000100, "R3 only core1 timer irq (bit 2)", DW'(irq), 32'h4);
    wr32(tmr_win(1) + 12'hC, 32'h1, 0);
    check(irq === 6'b000000, "R9 status cleared by writing 1", DW'(irq), 0);
    wr32(wdg_win(2), 32'd3, 0);
    wr32(wdg_win(2) + 12'h8, 32'h3, 0);
    repeat (10) @(negedge clk);
    check(irq === 6'b100000, "R3 only core2 watchdog irq (bit 5)", DW'(irq), 32'h20);
    rd32(wdg_win(2) + 12'h4, 0, a);
    check(a !== '0 && a <= 32'd3, "R10 auto-reload keeps counting", a, 3);
    wr32(wdg_win(2) + 12'h8, 32'h0, 0);
    wr32(wdg_win(2) + 12'hC, 32'h1, 0);
    check(irq === '0, "R9 watchdog status cleared", DW'(irq), 0);
  endtask

  task automatic t_enable_reload;
    logic [DW-1:0] v;
    wr32(wdg_win(0), 32'd7, 0);
    wr32(wdg_win(0) + 12'h4, 32'd0, 0);
    rd32(wdg_win(0) + 12'h4, 0, v);
    check(v === '0, "R9 count register writable", v, 0);
    wr32(wdg_win(0) + 12'h8, 32'h3, 0);
    rd32(wdg_win(0) + 12'h4, 0, v);
    check(v !== '0 && v <= 32'd7, "R11 enable with zero count loads reload value", v, 7);
    rd32(wdg_win(0) + 12'h8, 0, v);
    check(v === 32'h3, "R9 control readback", v, 3);
    wr32(wdg_win(0) + 12'h8, 32'h0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alias();
    t_direct();
    t_errors();
    t_backpressure();
    t_count();
    t_enable_reload();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule